// File: doc/BRIEF.md
# RTC Alarm Match and Interrupt Status

This block sits beside the time-keeping counters of a real-time clock. It compares the live seconds, minutes and hours bytes against three programmable alarm bytes. It also keeps the clock's interrupt status byte, which records three kinds of event: periodic ticks, alarm hits and the end of each once-per-second time update. The counters and the rate generator live elsewhere and send the block one-cycle pulses. A single read strobe from the register interface marks a read of the status byte.

The alarm bytes are checked only when an update-ended pulse arrives. One matching second therefore produces exactly one alarm event. An alarm byte whose two top bits are both set acts as a wildcard and matches any time value. An event flag is sticky: it stays set until software reads the status byte. The read returns the flags and clears them on the same clock edge. The request bit and the active-low interrupt pin come from the flags qualified by their enable bits. The flags themselves are recorded whatever the enables are.

Top module: `rtc_alarm_irq`

## Requirements
- R1: While reset is held and on the first cycle after it, `stat_q` reads 0x00 and `irq_n` is 1.
- R2: On a cycle with `upd_evt` high, the alarm flag (`stat_q` bit 5) is set from the next cycle when each of the three alarm bytes equals its time byte. If any non-wildcard field differs, the alarm flag is not set.
- R3: An alarm byte with bits 7 and 6 both 1 (0xC0 to 0xFF) matches any time value. A byte with only bit 7 set (for example 0x80) must still match exactly.
- R4: Without `upd_evt`, a full alarm match sets no alarm flag.
- R5: `prd_evt` sets bit 6 and `upd_evt` sets bit 4 from the next cycle, whatever the enable inputs are.
- R6: `stat_q` bit 7 is 1 exactly when some flag is set together with its enable: bit 6 with `en_prd`, bit 5 with `en_alm`, bit 4 with `en_upd`. Bits 3 to 0 always read 0.
- R7: On a cycle with `stat_rd` high, `stat_q` shows the flags as they were before the read. On the next cycle all flags are 0, except where R8 applies.
- R8: An event pulse in the same cycle as `stat_rd` leaves its flag set after the clear.
- R9: `irq_n` is always the inverse of `stat_q` bit 7. It goes high on the cycle after a clearing read that has no event in the same cycle.
- R10: Without `stat_rd`, a flag once set stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_now | input | 8 | Current seconds byte |
| min_now | input | 8 | Current minutes byte |
| hr_now | input | 8 | Current hours byte |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hr | input | 8 | Hours alarm byte |
| prd_evt | input | 1 | Periodic tick pulse |
| upd_evt | input | 1 | Update-ended pulse; also triggers the alarm compare |
| en_prd | input | 1 | Periodic interrupt enable |
| en_alm | input | 1 | Alarm interrupt enable |
| en_upd | input | 1 | Update-ended interrupt enable |
| stat_rd | input | 1 | Status byte read strobe (one cycle per read) |
| stat_q | output | 8 | Status byte: bit 7 request, bit 6 periodic, bit 5 alarm, bit 4 update-ended |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that event pulses and read strobes are sampled only at clock edges. A read strobe that coincides with an event is the case R8 allows. So the clear checks apply only to reads with no event pulse in the same cycle. The time and alarm bytes are assumed to be stable during the update-ended cycle. The stimulus sets all of them between edges, one cycle ahead. It mixes directed cases (exact match, a single differing field, wildcards at 0xC0 and 0xFF, the non-wildcard 0x80, and a read coinciding with an event) with a long run of random pulses, reads and enables. Its time values are drawn from a small set so that alarm matches are frequent.

// File: rtl/rtc_irq_pkg.sv
// Package: shared bit positions for the alarm/interrupt status block.
// Assumes an 8-bit status byte with the flag layout fixed by software.
package rtc_irq_pkg;
    localparam int STAT_W  = 8;
    localparam int N_EVT   = 3;
    // index of each event inside the internal event/flag vectors
    localparam int EV_PRD  = 2;
    localparam int EV_ALM  = 1;
    localparam int EV_UPD  = 0;
    // status byte positions (decoded by software, so fixed)
    localparam int ST_REQ  = 7;
    localparam int ST_FLG_LO = 4;
endpackage

// File: rtl/rtc_field_match.sv
// Module: rtc_field_match
// Compares one alarm byte against one time byte. A byte whose two top
// bits are both set is a wildcard and always matches.
// Assumes DATA_W >= 2.
module rtc_field_match #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] time_val,
    input  logic [DATA_W-1:0] alarm_val,
    output logic              hit
);
    logic wild;

    // wildcard detect and equality compare
    always_comb begin
        wild = &alarm_val[DATA_W-1 -: 2];
        hit  = wild || (alarm_val == time_val);
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
// Module: rtc_alarm_cmp
// Runs one field comparator per time field and reports a full match
// only when every field hits. Purely combinational.
// Assumes the field vectors are stable while the result is sampled.
module rtc_alarm_cmp #(
    parameter int DATA_W   = 8,
    parameter int N_FIELDS = 3
) (
    input  logic [N_FIELDS-1:0][DATA_W-1:0] now_vals,
    input  logic [N_FIELDS-1:0][DATA_W-1:0] alm_vals,
    output logic                            all_hit
);
    logic [N_FIELDS-1:0] hits;

    for (genvar gi = 0; gi < N_FIELDS; gi++) begin : g_field
        rtc_field_match #(.DATA_W(DATA_W)) u_match (
            .time_val  (now_vals[gi]),
            .alarm_val (alm_vals[gi]),
            .hit       (hits[gi])
        );
    end

    // reduce the per-field hits
    always_comb all_hit = &hits;
endmodule

// File: rtl/rtc_flag_bank.sv
// Module: rtc_flag_bank
// Sticky event flags. A read strobe clears them at the clock edge. An
// event pulse in the same cycle wins over the clear, so no event is lost.
// Assumes one-cycle event pulses; synchronous active-low reset.
module rtc_flag_bank #(
    parameter int N_FLAGS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAGS-1:0] evt,
    input  logic               clr,
    output logic [N_FLAGS-1:0] flags
);
    // set on event, clear on read, event overrides clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= (clr ? '0 : flags) | evt;
    end
endmodule

// File: rtl/rtc_alarm_irq.sv
// Module: rtc_alarm_irq (top)
// Alarm compare plus interrupt status byte of a real-time clock. The
// alarm is evaluated only on the update-ended pulse. Flags are sticky
// and clear when the status byte is read. The request bit and the
// active-low pin follow the flags gated by their enables.
// Assumes pulses last one cycle and time/alarm bytes are stable at the
// update-ended edge.
module rtc_alarm_irq
    import rtc_irq_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int N_FIELDS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sec_now,
    input  logic [DATA_W-1:0] min_now,
    input  logic [DATA_W-1:0] hr_now,
    input  logic [DATA_W-1:0] alm_sec,
    input  logic [DATA_W-1:0] alm_min,
    input  logic [DATA_W-1:0] alm_hr,
    input  logic              prd_evt,
    input  logic              upd_evt,
    input  logic              en_prd,
    input  logic              en_alm,
    input  logic              en_upd,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] stat_q,
    output logic              irq_n
);
    localparam int PAD_W = ST_FLG_LO;

    logic [N_FIELDS-1:0][DATA_W-1:0] now_vec;
    logic [N_FIELDS-1:0][DATA_W-1:0] alm_vec;
    logic                            match;
    logic [N_EVT-1:0]                evt_vec;
    logic [N_EVT-1:0]                en_vec;
    logic [N_EVT-1:0]                flags;
    logic                            req;

    // pack the time and alarm fields
    always_comb begin
        now_vec = {hr_now, min_now, sec_now};
        alm_vec = {alm_hr, alm_min, alm_sec};
    end

    rtc_alarm_cmp #(.DATA_W(DATA_W), .N_FIELDS(N_FIELDS)) u_cmp (
        .now_vals (now_vec),
        .alm_vals (alm_vec),
        .all_hit  (match)
    );

    // gather event pulses and enables in flag order
    always_comb begin
        evt_vec         = '0;
        evt_vec[EV_PRD] = prd_evt;
        evt_vec[EV_ALM] = upd_evt & match;
        evt_vec[EV_UPD] = upd_evt;
        en_vec          = '0;
        en_vec[EV_PRD]  = en_prd;
        en_vec[EV_ALM]  = en_alm;
        en_vec[EV_UPD]  = en_upd;
    end

    rtc_flag_bank #(.N_FLAGS(N_EVT)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt_vec),
        .clr   (stat_rd),
        .flags (flags)
    );

    // request bit, status byte and pin
    always_comb begin
        req    = |(flags & en_vec);
        stat_q = {req, flags, {PAD_W{1'b0}}};
        irq_n  = ~req;
    end
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
// Module: rtc_alarm_irq_chk
// Temporal checks on the status byte and pin of rtc_alarm_irq, seen
// from its ports only. Bound to every instance of the top.
module rtc_alarm_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       prd_evt,
    input logic       upd_evt,
    input logic       stat_rd,
    input logic [7:0] stat_q,
    input logic       irq_n
);
    // R5: a periodic pulse leaves its flag set
    p_prd_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prd_evt |=> stat_q[6]);

    // R5: an update-ended pulse leaves its flag set
    p_upd_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt |=> stat_q[4]);

    // R4: the alarm flag only rises after an update-ended pulse
    p_alarm_needs_upd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[5]) |-> $past(upd_evt));

    // R7: a read with no coinciding event empties every flag
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !prd_evt && !upd_evt) |=> (stat_q[6:4] == 3'b000));

    // R9: the pin releases after such a read
    p_pin_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !prd_evt && !upd_evt) |=> irq_n);

    // R10: without a read, no flag falls
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((stat_q[6:4] & $past(stat_q[6:4])) == $past(stat_q[6:4])));
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .prd_evt (prd_evt),
    .upd_evt (upd_evt),
    .stat_rd (stat_rd),
    .stat_q  (stat_q),
    .irq_n   (irq_n)
);

// File: tb/test_rtc_alarm_irq.sv
// Bench for rtc_alarm_irq. A behavioural model of the flags is checked
// against the ports on every clock, a little after each falling edge.
module test_rtc_alarm_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sec_now = 0, min_now = 0, hr_now = 0;
    logic [7:0] alm_sec = 0, alm_min = 0, alm_hr = 0;
    logic       prd_evt = 0, upd_evt = 0;
    logic       en_prd = 0, en_alm = 0, en_upd = 0;
    logic       stat_rd = 0;
    logic [7:0] stat_q;
    logic       irq_n;

    int n_checks = 0;
    int n_fails  = 0;
    bit m_prd = 0, m_alm = 0, m_upd = 0;   // model flags
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    rtc_alarm_irq i_rtc_alarm_irq (
        .clk(clk), .rst_n(rst_n),
        .sec_now(sec_now), .min_now(min_now), .hr_now(hr_now),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
        .prd_evt(prd_evt), .upd_evt(upd_evt),
        .en_prd(en_prd), .en_alm(en_alm), .en_upd(en_upd),
        .stat_rd(stat_rd), .stat_q(stat_q), .irq_n(irq_n)
    );

    function automatic bit fmatch(input logic [7:0] a, input logic [7:0] t);
        return (a >= 8'hC0) || (a == t);
    endfunction

    function automatic logic [7:0] model_stat();
        bit r;
        r = (m_prd && en_prd) || (m_alm && en_alm) || (m_upd && en_upd);
        return {r, m_prd, m_alm, m_upd, 4'b0000};
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare ports with the model, then advance one clock
    task automatic cycle(input string tag);
        logic [7:0] e;
        bit am;
        #1;
        e = model_stat();
        check8({tag, " stat_q"}, stat_q, e);
        check8({tag, " irq_n (R9)"}, {7'd0, irq_n}, {7'd0, ~e[7]});
        am = fmatch(alm_sec, sec_now) && fmatch(alm_min, min_now) && fmatch(alm_hr, hr_now);
        @(posedge clk);
        if (stat_rd) begin m_prd = 0; m_alm = 0; m_upd = 0; end
        if (prd_evt) m_prd = 1;
        if (upd_evt) begin m_upd = 1; if (am) m_alm = 1; end
        @(negedge clk);
        prd_evt = 0; upd_evt = 0; stat_rd = 0;
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
        sec_now = s; min_now = m; hr_now = h;
    endtask

    task automatic set_alarm(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
        alm_sec = s; alm_min = m; alm_hr = h;
    endtask

    task automatic clear_all();
        stat_rd = 1; cycle("R7 clear");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        @(negedge clk);
        // R1: reset state while reset held
        check8("R1 reset stat_q", stat_q, 8'h00);
        check8("R1 reset irq_n", {7'd0, irq_n}, 8'h01);
        prd_evt = 1; upd_evt = 1;           // ignored during reset
        @(negedge clk);
        prd_evt = 0; upd_evt = 0;
        rst_n = 1;
        cycle("R1 after reset");

        // R5: flags set without enables, request stays low (R6)
        prd_evt = 1; cycle("R5 prd");
        cycle("R5/R6 prd no enable");
        upd_evt = 1; set_alarm(8'h01, 8'h02, 8'h03); cycle("R5 upd");
        cycle("R5/R6 upd no enable");
        // R6: enable makes request and pin active
        en_prd = 1; cycle("R6 en_prd");
        // R10: flags hold
        repeat (4) cycle("R10 hold");
        // R7: read returns old flags then clears; R9 pin releases
        stat_rd = 1; cycle("R7 read");
        cycle("R7/R9 after read");
        en_prd = 0;

        // R2: exact match on update
        en_alm = 1;
        set_time(8'h15, 8'h30, 8'h12); set_alarm(8'h15, 8'h30, 8'h12);
        upd_evt = 1; cycle("R2 match");
        cycle("R2 alarm flag");
        clear_all();
        // R2: one field differs
        set_alarm(8'h15, 8'h31, 8'h12);
        upd_evt = 1; cycle("R2 mismatch");
        cycle("R2 no alarm");
        clear_all();
        // R4: match without update pulse
        set_alarm(8'h15, 8'h30, 8'h12);
        repeat (3) cycle("R4 no upd");
        // R3: wildcards 0xC0 and 0xFF
        set_alarm(8'hC0, 8'hFF, 8'h12); set_time(8'h59, 8'h07, 8'h12);
        upd_evt = 1; cycle("R3 wildcard");
        cycle("R3 wildcard flag");
        clear_all();
        // R3: 0x80 is not a wildcard
        set_alarm(8'h80, 8'hC0, 8'hC0);
        upd_evt = 1; cycle("R3 0x80 differs");
        cycle("R3 0x80 no alarm");
        set_time(8'h80, 8'h00, 8'h00);
        stat_rd = 1; upd_evt = 1; cycle("R3/R8 0x80 exact with read");
        cycle("R3/R8 0x80 flag");
        // R8: periodic event coincides with read
        en_prd = 1;
        stat_rd = 1; prd_evt = 1; cycle("R8 read+prd");
        cycle("R8 prd survives");
        clear_all();
        cycle("R9 pin high");

        // mixed random traffic (R2 R5 R6 R7 R8 R10)
        for (int i = 0; i < 2000; i++) begin
            set_time(8'($urandom_range(0, 2)), 8'($urandom_range(0, 1)), 8'h05);
            if ($urandom_range(0, 9) == 0) set_alarm(8'($urandom_range(0, 2)),
                ($urandom_range(0, 3) == 0) ? 8'hC5 : 8'($urandom_range(0, 1)), 8'h05);
            prd_evt = ($urandom_range(0, 7) == 0);
            upd_evt = ($urandom_range(0, 3) == 0);
            stat_rd = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 15) == 0) begin
                en_prd = 1'($urandom); en_alm = 1'($urandom); en_upd = 1'($urandom);
            end
            cycle("R6 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule